// File: doc/BRIEF.md
# Endian-Configurable Load/Store Adapter

This block connects a 32-bit processor load/store port to a small byte-addressed local RAM of 2^AW bytes. It carries out byte, halfword and word reads and writes. A configuration pin selects little- or big-endian lane order. Halfword and byte loads can be zero- or sign-extended. The address is masked to the RAM size, with the alignment bits of the access width cleared. An address with any bit outside that mask raises a bus error, which covers both misalignment and addresses past the end of the RAM.

Byte accesses above a fixed I/O floor (0x0500_0000) do not touch the RAM. They go to a character port instead. A byte write to the transmit address hands the character to a valid/ready output stream, except that a carriage return is discarded. A byte read of the receive address takes one character from a valid/ready input stream.

The processor side uses a request/ready handshake. The processor holds `cpu_req` and the access fields until a clock edge finds the adapter idle, and may drop them after that edge. Completion is a single-cycle `cpu_rdy` pulse, and `cpu_rdata` and `cpu_berr` are valid only in that cycle. A RAM access completes in the cycle after acceptance. The character streams apply back-pressure in the usual way. `tx_valid` with `tx_data` held stable stays up until `tx_ready` is seen, and `rx_ready` stays up until `rx_valid` is seen. Until that transfer takes place, the processor access stays pending.

Top module: `mem_endian_port`

## Requirements
- R1: While reset is applied and after its release, `cpu_rdy`, `cpu_berr`, `tx_valid` and `rx_ready` are low until a request is accepted.
- R2: A request is accepted at a clock edge where `cpu_req` is high and no access is pending. For a RAM or bus-error access, `cpu_rdy` is high for exactly one cycle, the cycle right after that edge.
- R3: `cpu_size` encodes 00 = byte, 01 = halfword, 1x = word. The RAM location is the address ANDed with 2^AW-1, with bit 0 also cleared for halfwords and bits 1:0 also cleared for words. Byte 2^AW-1 is reachable.
- R4: `cpu_berr` is high in the completion cycle when the address has any bit set outside the mask for its width. A load with a bus error returns 0. A byte address equal to the I/O floor is still a bus error.
- R5: An access with a bus error leaves the RAM unchanged.
- R6: With `big_endian` low, data bits 7:0 go to the lowest byte address for both words and halfwords.
- R7: With `big_endian` high, bits 31:24 of a word, or bits 15:8 of a halfword, go to the lowest byte address.
- R8: A byte access gives the same result in both endian modes.
- R9: With `cpu_signed` high, a halfword load sign-extends bit 15 and a byte load sign-extends bit 7. With `cpu_signed` low, the load is zero-extended.
- R10: A byte write to 0x05FF_FECB presents its low data byte on `tx_data` with `tx_valid`, and stays pending until `tx_ready`. A value of 0x0D completes at once with no `tx_valid`. Halfword and word accesses are never diverted to the port.
- R11: A byte read of 0x05FF_FECD raises `rx_ready`, stays pending until `rx_valid`, and returns `rx_data` extended according to `cpu_signed`.
- R12: Any other byte access above 0x0500_0000 completes in one cycle with no bus error. A write there changes no RAM byte, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian | input | 1 | Lane order: 1 = big-endian, sampled on acceptance |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | Access width code |
| cpu_signed | input | 1 | Sign-extend narrow loads |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_rdy | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Load result, valid with `cpu_rdy` |
| cpu_berr | output | 1 | Bus error, valid with `cpu_rdy` |
| tx_valid | output | 1 | Outgoing character valid |
| tx_ready | input | 1 | Character sink ready |
| tx_data | output | 8 | Outgoing character |
| rx_valid | input | 1 | Incoming character valid |
| rx_ready | output | 1 | Adapter is taking a character |
| rx_data | input | 8 | Incoming character |

## Verification
Lane-order or extension faults show up at the ports on the first load that follows a write, as a wrong `cpu_rdata` in its completion cycle. This holds even when the write went through in the other endian mode. A bus error that writes anyway only shows on a later load of the aliased location, so every error access is followed by a read-back. A pending-state fault shows within one cycle: `cpu_rdy` is missing or repeated, or a stream handshake is dropped while back-pressure is held.

// File: rtl/memx_pkg.sv
package memx_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'b00,
    ACC_HALF = 2'b01,
    ACC_WORD = 2'b10,
    ACC_WALT = 2'b11
  } acc_size_e;

  localparam int LANES = 4;
  localparam logic [7:0] CHAR_CR = 8'h0D;
endpackage

// File: rtl/memx_addr_decode.sv
module memx_addr_decode
  import memx_pkg::*;
#(
  parameter int          AW       = 10,
  parameter logic [31:0] IO_FLOOR = 32'h0500_0000,
  parameter logic [31:0] TX_ADDR  = 32'h05FF_FECB,
  parameter logic [31:0] RX_ADDR  = 32'h05FF_FECD
) (
  input  logic [31:0]   addr,
  input  acc_size_e     size,
  output logic [AW-1:0] phys,
  output logic          bus_err,
  output logic          io_hit,
  output logic          io_tx,
  output logic          io_rx
);
  localparam logic [31:0] MASK_B = 32'((64'd1 << AW) - 64'd1);
  localparam logic [31:0] MASK_H = MASK_B & ~32'd1;
  localparam logic [31:0] MASK_W = MASK_B & ~32'd3;

  logic [31:0] mask;

  always_comb begin
    unique case (size)
      ACC_BYTE: mask = MASK_B;
      ACC_HALF: mask = MASK_H;
      default:  mask = MASK_W;
    endcase
  end

  assign io_hit  = (size == ACC_BYTE) && (addr > IO_FLOOR);
  assign io_tx   = io_hit && (addr == TX_ADDR);
  assign io_rx   = io_hit && (addr == RX_ADDR);
  assign bus_err = !io_hit && ((addr & ~mask) != 32'd0);
  assign phys    = AW'(addr & mask);
endmodule

// File: rtl/memx_lane_order.sv
module memx_lane_order
  import memx_pkg::*;
(
  input  logic            big,
  input  acc_size_e       size,
  input  logic            sgn,
  input  logic [31:0]     wdata,
  input  logic [3:0][7:0] rbytes,
  output logic [3:0][7:0] wbytes,
  output logic [3:0]      wmask,
  output logic [31:0]     rdata
);
  logic [15:0] half_v;

  always_comb begin
    wbytes = '0;
    wmask  = '0;
    rdata  = '0;
    half_v = '0;
    unique case (size)
      ACC_BYTE: begin
        wbytes[0] = wdata[7:0];
        wmask     = 4'b0001;
        rdata     = sgn ? {{24{rbytes[0][7]}}, rbytes[0]} : {24'd0, rbytes[0]};
      end
      ACC_HALF: begin
        if (big) begin
          wbytes[0] = wdata[15:8];
          wbytes[1] = wdata[7:0];
          half_v    = {rbytes[0], rbytes[1]};
        end else begin
          wbytes[0] = wdata[7:0];
          wbytes[1] = wdata[15:8];
          half_v    = {rbytes[1], rbytes[0]};
        end
        wmask = 4'b0011;
        rdata = sgn ? {{16{half_v[15]}}, half_v} : {16'd0, half_v};
      end
      default: begin
        for (int k = 0; k < LANES; k++) begin
          wbytes[k]       = big ? wdata[8*(LANES-1-k) +: 8] : wdata[8*k +: 8];
          rdata[8*k +: 8] = big ? rbytes[LANES-1-k] : rbytes[k];
        end
        wmask = 4'b1111;
      end
    endcase
  end
endmodule

// File: rtl/memx_byte_ram.sv
module memx_byte_ram
  import memx_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [AW-1:0]   base,
  input  logic [3:0]      wmask,
  input  logic [3:0][7:0] wbytes,
  output logic [3:0][7:0] rbytes
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] idx [LANES];

  always_comb begin
    for (int k = 0; k < LANES; k++) idx[k] = base + AW'(k);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (wr_en && wmask[k]) mem[idx[k]] <= wbytes[k];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_rd
    assign rbytes[g] = mem[idx[g]];
  end
endmodule

// File: rtl/mem_endian_port.sv
module mem_endian_port
  import memx_pkg::*;
#(
  parameter int          AW       = 10,
  parameter logic [31:0] IO_FLOOR = 32'h0500_0000,
  parameter logic [31:0] TX_ADDR  = 32'h05FF_FECB,
  parameter logic [31:0] RX_ADDR  = 32'h05FF_FECD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_endian,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_size,
  input  logic        cpu_signed,
  input  logic [31:0] cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic        cpu_rdy,
  output logic [31:0] cpu_rdata,
  output logic        cpu_berr,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data
);
  logic        busy;
  logic        accept;
  logic [31:0] r_addr;
  logic [31:0] r_wdata;
  logic        r_we, r_sgn, r_big;
  acc_size_e   r_size;

  logic [AW-1:0]   dec_phys;
  logic            dec_berr, dec_io, dec_tx, dec_rx;
  logic [3:0][7:0] wbytes, rbytes;
  logic [3:0]      wmask;
  logic [31:0]     lane_rdata;
  logic            need_tx, need_rx, ram_we;
  logic [31:0]     rx_ext;

  assign accept = cpu_req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_we    <= 1'b0;
      r_sgn   <= 1'b0;
      r_big   <= 1'b0;
      r_size  <= ACC_BYTE;
    end else if (accept) begin
      busy    <= 1'b1;
      r_addr  <= cpu_addr;
      r_wdata <= cpu_wdata;
      r_we    <= cpu_we;
      r_sgn   <= cpu_signed;
      r_big   <= big_endian;
      r_size  <= acc_size_e'(cpu_size);
    end else if (cpu_rdy) begin
      busy <= 1'b0;
    end
  end

  memx_addr_decode #(
    .AW(AW), .IO_FLOOR(IO_FLOOR), .TX_ADDR(TX_ADDR), .RX_ADDR(RX_ADDR)
  ) u_dec (
    .addr(r_addr), .size(r_size), .phys(dec_phys), .bus_err(dec_berr),
    .io_hit(dec_io), .io_tx(dec_tx), .io_rx(dec_rx)
  );

  memx_lane_order u_lanes (
    .big(r_big), .size(r_size), .sgn(r_sgn), .wdata(r_wdata),
    .rbytes(rbytes), .wbytes(wbytes), .wmask(wmask), .rdata(lane_rdata)
  );

  memx_byte_ram #(.AW(AW)) u_ram (
    .clk(clk), .wr_en(ram_we), .base(dec_phys), .wmask(wmask),
    .wbytes(wbytes), .rbytes(rbytes)
  );

  assign need_tx  = busy && dec_tx && r_we && (r_wdata[7:0] != CHAR_CR);
  assign need_rx  = busy && dec_rx && !r_we;
  assign tx_valid = need_tx;
  assign tx_data  = r_wdata[7:0];
  assign rx_ready = need_rx;
  assign cpu_rdy  = busy && (need_tx ? tx_ready : (need_rx ? rx_valid : 1'b1));
  assign cpu_berr = busy && dec_berr;
  assign ram_we   = busy && cpu_rdy && r_we && !dec_berr && !dec_io;
  assign rx_ext   = r_sgn ? {{24{rx_data[7]}}, rx_data} : {24'd0, rx_data};

  always_comb begin
    cpu_rdata = '0;
    if (busy && !r_we && !dec_berr) begin
      if (dec_io) cpu_rdata = need_rx ? rx_ext : 32'd0;
      else        cpu_rdata = lane_rdata;
    end
  end

  // R2: every accepted access produces a completion or a stream handshake next cycle
  a_r2_prompt_finish: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cpu_rdy || tx_valid || rx_ready));
  // R2: completion is a single pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |=> !cpu_rdy);
  // R4: bus error only reported in a completion cycle
  a_r4_berr_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_berr |-> cpu_rdy);
  // R10: back-pressured character is held
  a_r10_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
  // R10: carriage return never leaves the port
  a_r10_no_cr: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_data != CHAR_CR));
  // R11: receive request held until a character arrives
  a_r11_rx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && !rx_valid) |=> rx_ready);
  // R12: port traffic never carries a bus error
  a_r12_io_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || rx_ready) |-> !cpu_berr);
endmodule

// File: tb/test_mem_endian_port.sv
module test_mem_endian_port;
  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic        sg;
    logic        be;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        eberr;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'b10, 1'b0, 1'b0, 32'h10,        32'h11223344, 32'h0,        1'b0, 8'd6},  // R6 write LE word
    '{1'b0, 2'b10, 1'b0, 1'b0, 32'h10,        32'h0,        32'h11223344, 1'b0, 8'd6},  // R6
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h10,        32'h0,        32'h44,       1'b0, 8'd8},  // R8 LE byte
    '{1'b0, 2'b00, 1'b0, 1'b1, 32'h10,        32'h0,        32'h44,       1'b0, 8'd8},  // R8 BE byte
    '{1'b0, 2'b01, 1'b0, 1'b1, 32'h10,        32'h0,        32'h4433,     1'b0, 8'd7},  // R7 BE half
    '{1'b0, 2'b10, 1'b0, 1'b1, 32'h10,        32'h0,        32'h44332211, 1'b0, 8'd7},  // R7 BE word
    '{1'b1, 2'b01, 1'b0, 1'b1, 32'h20,        32'h000080F1, 32'h0,        1'b0, 8'd7},  // R7 BE half write
    '{1'b0, 2'b01, 1'b1, 1'b0, 32'h20,        32'h0,        32'hFFFFF180, 1'b0, 8'd9},  // R9
    '{1'b0, 2'b01, 1'b1, 1'b1, 32'h20,        32'h0,        32'hFFFF80F1, 1'b0, 8'd9},  // R9
    '{1'b0, 2'b00, 1'b1, 1'b1, 32'h21,        32'h0,        32'hFFFFFFF1, 1'b0, 8'd9},  // R9
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h21,        32'h0,        32'hF1,       1'b0, 8'd9},  // R9
    '{1'b1, 2'b10, 1'b0, 1'b0, 32'h12,        32'hDEADBEEF, 32'h0,        1'b1, 8'd4},  // R4 misaligned
    '{1'b0, 2'b10, 1'b0, 1'b0, 32'h10,        32'h0,        32'h11223344, 1'b0, 8'd5},  // R5 unchanged
    '{1'b0, 2'b10, 1'b0, 1'b0, 32'h400,       32'h0,        32'h0,        1'b1, 8'd4},  // R4 past end
    '{1'b1, 2'b00, 1'b0, 1'b0, 32'h410,       32'h99,       32'h0,        1'b1, 8'd4},  // R4 alias write
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h10,        32'h0,        32'h44,       1'b0, 8'd5},  // R5 no alias
    '{1'b0, 2'b01, 1'b0, 1'b0, 32'h11,        32'h0,        32'h0,        1'b1, 8'd4},  // R4 odd half
    '{1'b1, 2'b00, 1'b0, 1'b0, 32'h3FF,       32'h5A,       32'h0,        1'b0, 8'd3},  // R3 top byte
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h3FF,       32'h0,        32'h5A,       1'b0, 8'd3},  // R3
    '{1'b0, 2'b11, 1'b0, 1'b0, 32'h10,        32'h0,        32'h11223344, 1'b0, 8'd3},  // R3 code 11 = word
    '{1'b1, 2'b00, 1'b0, 1'b0, 32'h05000010,  32'h77,       32'h0,        1'b0, 8'd12}, // R12 write
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h10,        32'h0,        32'h44,       1'b0, 8'd12}, // R12 RAM untouched
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h05000010,  32'h0,        32'h0,        1'b0, 8'd12}, // R12 read zero
    '{1'b0, 2'b00, 1'b0, 1'b0, 32'h05000000,  32'h0,        32'h0,        1'b1, 8'd4},  // R4 floor itself
    '{1'b1, 2'b01, 1'b0, 1'b0, 32'h05FFFECA,  32'h41,       32'h0,        1'b1, 8'd10}  // R10 half not diverted
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic big_endian = 1'b0;
  logic cpu_req = 1'b0;
  logic cpu_we = 1'b0;
  logic [1:0] cpu_size = 2'b00;
  logic cpu_signed = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic cpu_rdy, cpu_berr, tx_valid, rx_ready;
  logic [31:0] cpu_rdata;
  logic [7:0] tx_data;
  logic tx_ready = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;

  int n_run = 0;
  int n_fail = 0;
  int txv_seen = 0;

  always #5 clk = ~clk;

  mem_endian_port i_mem_endian_port (
    .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .cpu_req(cpu_req),
    .cpu_we(cpu_we), .cpu_size(cpu_size), .cpu_signed(cpu_signed),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdy(cpu_rdy),
    .cpu_rdata(cpu_rdata), .cpu_berr(cpu_berr), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data)
  );

  always @(negedge clk) if (tx_valid) txv_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input logic we, input logic [1:0] sz, input logic sg,
                       input logic be, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_we = we; cpu_size = sz; cpu_signed = sg; big_endian = be;
    cpu_addr = a; cpu_wdata = d; cpu_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic do_access(input vec_t v, output logic [31:0] rd,
                           output logic eb, output int lat);
    start(v.we, v.sz, v.sg, v.be, v.addr, v.wd);
    lat = 0;
    while (!cpu_rdy && lat < 20) begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    rd = cpu_rdata;
    eb = cpu_berr;
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic eb;
    int lat;
    string tg;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 rdy in reset", {31'd0, cpu_rdy}, 32'd0);
    chk("R1 tx_valid in reset", {31'd0, tx_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle outputs", {28'd0, cpu_rdy, cpu_berr, tx_valid, rx_ready}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      do_access(TBL[i], rd, eb, lat);
      tg = $sformatf("R%0d row %0d", TBL[i].tag, i);
      chk({tg, " rdata"}, rd, TBL[i].exp);
      chk({tg, " berr"}, {31'd0, eb}, {31'd0, TBL[i].eberr});
      chk({"R2 latency ", tg}, lat, 0);
    end
    chk("R12 no tx_valid during table", txv_seen, 0);

    // R10: transmit with back-pressure
    start(1'b1, 2'b00, 1'b0, 1'b0, 32'h05FFFECB, 32'h0000_0041);
    chk("R10 tx_valid", {31'd0, tx_valid}, 32'd1);
    chk("R10 tx_data", {24'd0, tx_data}, 32'h41);
    chk("R10 stall rdy", {31'd0, cpu_rdy}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R10 held tx_data", {24'd0, tx_data}, 32'h41);
    chk("R10 still stalled", {31'd0, cpu_rdy}, 32'd0);
    tx_ready = 1'b1;
    #1;
    chk("R10 rdy on tx_ready", {30'd0, cpu_rdy, cpu_berr}, 32'd2);
    @(posedge clk); @(negedge clk);
    tx_ready = 1'b0;
    chk("R10 tx_valid dropped", {31'd0, tx_valid}, 32'd0);

    // R10: carriage return dropped
    txv_seen = 0;
    start(1'b1, 2'b00, 1'b0, 1'b0, 32'h05FFFECB, 32'h0000_000D);
    chk("R10 CR completes", {31'd0, cpu_rdy}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R10 CR not sent", txv_seen, 0);

    // R11: receive, signed, waiting for data
    start(1'b0, 2'b00, 1'b1, 1'b1, 32'h05FFFECD, 32'h0);
    chk("R11 rx_ready", {31'd0, rx_ready}, 32'd1);
    chk("R11 waits", {31'd0, cpu_rdy}, 32'd0);
    @(posedge clk); @(negedge clk);
    rx_data = 8'h85; rx_valid = 1'b1;
    #1;
    chk("R11 rdy", {31'd0, cpu_rdy}, 32'd1);
    chk("R11 signed char", cpu_rdata, 32'hFFFFFF85);
    @(posedge clk); @(negedge clk);
    chk("R11 rx_ready dropped", {31'd0, rx_ready}, 32'd0);

    // R11: receive unsigned with data already waiting
    start(1'b0, 2'b00, 1'b0, 1'b0, 32'h05FFFECD, 32'h0);
    chk("R11 immediate rdy", {31'd0, cpu_rdy}, 32'd1);
    chk("R11 unsigned char", cpu_rdata, 32'h85);
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule